// File: doc/BRIEF.md
# Four-Accumulator Fixed-Point ALU

This execution unit sits in the arithmetic datapath of a small fixed-point signal processor. It keeps four accumulators, each wider than the 8-bit data word by four guard bits, so that a run of additions grows into spare headroom rather than wrapping. Each cycle it may accept one already-decoded instruction. The instruction carries a 3-bit major opcode, a 5-bit function code, a destination accumulator index, a source accumulator index and a 6-bit immediate.

The unit acts only when the major opcode is `000`. Bit 4 of the function code picks the operand kind. When it is clear, the destination accumulator is combined with a second accumulator. When it is set, the immediate is sign-extended and used instead, or the operation has one operand. The result is written on the clock edge that follows the instruction. Four status flags are updated on the same edge: zero, negative, carry and overflow. A compare updates the flags and leaves every accumulator unchanged. All arithmetic is two's complement on 12 bits.

The asynchronous active-low reset is released through a two-stage synchronizer. The unit therefore ignores instructions for the first two rising edges after the reset input goes high.

Top module: `dsp_acc_alu`

## Requirements
- R1: While reset is asserted, all four accumulators read zero and all four flags are low.
- R2: With opcode `000`, function `00000` writes dst+src and function `00001` writes dst−src into accumulator dst. The write happens on the next rising edge and wraps modulo 2^12.
- R3: Function `00010` writes dst AND src, `00011` writes dst OR src and `00100` writes dst XOR src. These operations clear the carry and overflow flags.
- R4: Function `00101` (compare) evaluates dst−src and sets all four flags as a subtraction does. No accumulator changes.
- R5: Functions `10000`, `10001`, `10010`, `10011` and `10100` perform add, subtract, AND, OR and XOR of accumulator dst with the 6-bit immediate. The immediate is sign-extended to 12 bits first.
- R6: Function `10111` adds one to dst, `11000` subtracts one from dst and `11010` writes 0−dst. Negating −2048 gives −2048 with overflow set, and negate sets carry exactly when dst was nonzero.
- R7: Function `10110` writes the bitwise inverse of dst, `11001` writes zero and `11111` writes dst back unchanged. Carry and overflow are cleared.
- R8: Function `11011` writes the magnitude of dst with carry clear. The value −2048 saturates to +2047 and sets overflow. Every other value leaves overflow clear.
- R9: After each executed operation, zero reports a result of 0 and negative reports bit 11 of the result. For add-type operations, carry is the carry out of bit 11. For subtract-type operations, carry is the unsigned borrow (dst < operand). Overflow is the signed two's-complement overflow.
- R10: In three cases nothing changes, neither an accumulator nor a flag: the valid strobe is low, the opcode is not `000`, or the function code is not one listed above.
- R11: An executed operation changes only the accumulator named by dst. The other three keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction fields are valid this cycle |
| instr_op | input | 3 | Major opcode; only `000` is executed |
| instr_func | input | 5 | Function code selecting the operation |
| instr_dst | input | 2 | Destination (and first operand) accumulator index |
| instr_src | input | 2 | Second operand accumulator index for register forms |
| instr_imm | input | 6 | Signed immediate for immediate forms |
| acc_flat | output | 48 | Accumulator i occupies bits [12*i+11 : 12*i] |
| flag_zero | output | 1 | Last result was zero |
| flag_neg | output | 1 | Last result had bit 11 set |
| flag_carry | output | 1 | Carry out or borrow of the last arithmetic operation |
| flag_ovf | output | 1 | Signed overflow or absolute-value saturation |

## Verification
Two things can land on the same clock edge. One is an accumulator write-back. The other is a read of that same accumulator by the instruction issued in the cycle right after it. Operations where destination and source are the same register, such as doubling one accumulator through repeated adds, also exercise this overlap. The bench provokes it with random back-to-back instructions whose indices often collide, and with a directed run that drives one accumulator from −32 down to −2048 by self-addition. Each cycle it judges the full accumulator and flag state against a bench model that applies the instructions strictly in sequence.

// File: rtl/dsp_alu_pkg.sv
package dsp_alu_pkg;

  localparam logic [2:0] OP_ALU = 3'b000;

  localparam logic [4:0] FN_ADD  = 5'b00000;
  localparam logic [4:0] FN_SUB  = 5'b00001;
  localparam logic [4:0] FN_AND  = 5'b00010;
  localparam logic [4:0] FN_OR   = 5'b00011;
  localparam logic [4:0] FN_XOR  = 5'b00100;
  localparam logic [4:0] FN_CMP  = 5'b00101;
  localparam logic [4:0] FN_ADDI = 5'b10000;
  localparam logic [4:0] FN_SUBI = 5'b10001;
  localparam logic [4:0] FN_ANDI = 5'b10010;
  localparam logic [4:0] FN_ORI  = 5'b10011;
  localparam logic [4:0] FN_XORI = 5'b10100;
  localparam logic [4:0] FN_NOT  = 5'b10110;
  localparam logic [4:0] FN_INC  = 5'b10111;
  localparam logic [4:0] FN_DEC  = 5'b11000;
  localparam logic [4:0] FN_CLR  = 5'b11001;
  localparam logic [4:0] FN_NEG  = 5'b11010;
  localparam logic [4:0] FN_ABS  = 5'b11011;
  localparam logic [4:0] FN_PASS = 5'b11111;

  typedef enum logic [3:0] {
    K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOT, K_CLR, K_PASS, K_NEG, K_ABS
  } alu_kind_e;

  typedef enum logic [1:0] {
    B_REG, B_IMM, B_ONE
  } bsel_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } alu_flags_t;

endpackage

// File: rtl/dsp_alu_decode.sv
module dsp_alu_decode
  import dsp_alu_pkg::*;
(
  input  logic       valid,
  input  logic [2:0] op,
  input  logic [4:0] func,
  output logic       exec,
  output logic       wr,
  output alu_kind_e  kind,
  output bsel_e      bsel
);

  logic known;

  always_comb begin
    known = 1'b1;
    kind  = K_PASS;
    bsel  = func[4] ? B_IMM : B_REG;
    case (func)
      FN_ADD, FN_ADDI: kind = K_ADD;
      FN_SUB, FN_SUBI, FN_CMP: kind = K_SUB;
      FN_AND, FN_ANDI: kind = K_AND;
      FN_OR,  FN_ORI:  kind = K_OR;
      FN_XOR, FN_XORI: kind = K_XOR;
      FN_NOT:  kind = K_NOT;
      FN_INC:  begin kind = K_ADD; bsel = B_ONE; end
      FN_DEC:  begin kind = K_SUB; bsel = B_ONE; end
      FN_CLR:  kind = K_CLR;
      FN_NEG:  kind = K_NEG;
      FN_ABS:  kind = K_ABS;
      FN_PASS: kind = K_PASS;
      default: known = 1'b0;
    endcase
    exec = valid && (op == OP_ALU) && known;
    wr   = exec && (func != FN_CMP);
  end

endmodule

// File: rtl/dsp_alu_core.sv
module dsp_alu_core
  import dsp_alu_pkg::*;
#(
  parameter int ACC_W = 12
) (
  input  alu_kind_e         kind,
  input  logic [ACC_W-1:0]  opa,
  input  logic [ACC_W-1:0]  opb,
  output logic [ACC_W-1:0]  res,
  output alu_flags_t        flags
);

  localparam int MSB = ACC_W - 1;
  localparam logic [ACC_W-1:0] MOST_NEG = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] MOST_POS = {1'b0, {(ACC_W-1){1'b1}}};

  logic [ACC_W:0] sum_x;
  logic [ACC_W:0] dif_x;
  logic [ACC_W:0] neg_x;
  logic           c_r;
  logic           v_r;

  always_comb begin
    sum_x = {1'b0, opa} + {1'b0, opb};
    dif_x = {1'b0, opa} - {1'b0, opb};
    neg_x = {(ACC_W+1){1'b0}} - {1'b0, opa};
    res   = '0;
    c_r   = 1'b0;
    v_r   = 1'b0;
    case (kind)
      K_ADD: begin
        res = sum_x[MSB:0];
        c_r = sum_x[ACC_W];
        v_r = (opa[MSB] == opb[MSB]) && (res[MSB] != opa[MSB]);
      end
      K_SUB: begin
        res = dif_x[MSB:0];
        c_r = dif_x[ACC_W];
        v_r = (opa[MSB] != opb[MSB]) && (res[MSB] != opa[MSB]);
      end
      K_AND:  res = opa & opb;
      K_OR:   res = opa | opb;
      K_XOR:  res = opa ^ opb;
      K_NOT:  res = ~opa;
      K_CLR:  res = '0;
      K_PASS: res = opa;
      K_NEG: begin
        res = neg_x[MSB:0];
        c_r = neg_x[ACC_W];
        v_r = (opa == MOST_NEG);
      end
      K_ABS: begin
        if (opa == MOST_NEG) begin
          res = MOST_POS;
          v_r = 1'b1;
        end else if (opa[MSB]) begin
          res = neg_x[MSB:0];
        end else begin
          res = opa;
        end
      end
      default: res = '0;
    endcase
    flags.z = (res == '0);
    flags.n = res[MSB];
    flags.c = c_r;
    flags.v = v_r;
  end

endmodule

// File: rtl/dsp_acc_bank.sv
module dsp_acc_bank #(
  parameter int ACC_W   = 12,
  parameter int NUM_ACC = 4,
  localparam int AW     = $clog2(NUM_ACC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_sel,
  input  logic [ACC_W-1:0]         wr_data,
  output logic [NUM_ACC*ACC_W-1:0] acc_flat
);

  for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
    logic             ld;
    logic [ACC_W-1:0] q;

    always_comb ld = wr_en && (wr_sel == AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= wr_data;
    end

    assign acc_flat[i*ACC_W +: ACC_W] = q;
  end

endmodule

// File: rtl/dsp_acc_alu.sv
module dsp_acc_alu
  import dsp_alu_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int GUARD_W  = 4,
  parameter int NUM_ACC  = 4,
  parameter int IMM_W    = 6,
  localparam int ACC_W   = DATA_W + GUARD_W,
  localparam int AW      = $clog2(NUM_ACC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     instr_valid,
  input  logic [2:0]               instr_op,
  input  logic [4:0]               instr_func,
  input  logic [AW-1:0]            instr_dst,
  input  logic [AW-1:0]            instr_src,
  input  logic [IMM_W-1:0]         instr_imm,
  output logic [NUM_ACC*ACC_W-1:0] acc_flat,
  output logic                     flag_zero,
  output logic                     flag_neg,
  output logic                     flag_carry,
  output logic                     flag_ovf
);

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic       exec;
  logic       wr;
  alu_kind_e  kind;
  bsel_e      bsel;

  dsp_alu_decode u_dec (
    .valid (instr_valid),
    .op    (instr_op),
    .func  (instr_func),
    .exec  (exec),
    .wr    (wr),
    .kind  (kind),
    .bsel  (bsel)
  );

  logic [ACC_W-1:0] opa;
  logic [ACC_W-1:0] opb;
  logic [ACC_W-1:0] res;
  alu_flags_t       core_flags;

  always_comb begin
    opa = acc_flat[instr_dst*ACC_W +: ACC_W];
    case (bsel)
      B_IMM:   opb = {{(ACC_W-IMM_W){instr_imm[IMM_W-1]}}, instr_imm};
      B_ONE:   opb = ACC_W'(1);
      default: opb = acc_flat[instr_src*ACC_W +: ACC_W];
    endcase
  end

  dsp_alu_core #(.ACC_W(ACC_W)) u_core (
    .kind  (kind),
    .opa   (opa),
    .opb   (opb),
    .res   (res),
    .flags (core_flags)
  );

  dsp_acc_bank #(.ACC_W(ACC_W), .NUM_ACC(NUM_ACC)) u_bank (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (wr),
    .wr_sel   (instr_dst),
    .wr_data  (res),
    .acc_flat (acc_flat)
  );

  // status flags: next-state and register processes
  alu_flags_t flags_d;
  alu_flags_t flags_q;

  always_comb begin
    flags_d = flags_q;
    if (exec) flags_d = core_flags;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) flags_q <= '0;
    else             flags_q <= flags_d;
  end

  assign flag_zero  = flags_q.z;
  assign flag_neg   = flags_q.n;
  assign flag_carry = flags_q.c;
  assign flag_ovf   = flags_q.v;

endmodule

// File: rtl/dsp_acc_alu_chk.sv
module dsp_acc_alu_chk #(
  parameter int ACC_W   = 12,
  parameter int NUM_ACC = 4,
  parameter int AW      = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     instr_valid,
  input logic [2:0]               instr_op,
  input logic [4:0]               instr_func,
  input logic [AW-1:0]            instr_dst,
  input logic [NUM_ACC*ACC_W-1:0] acc_flat,
  input logic                     flag_zero,
  input logic                     flag_neg,
  input logic                     flag_carry,
  input logic                     flag_ovf
);

  logic alu_sel;
  logic writes;

  always_comb begin
    alu_sel = instr_valid && (instr_op == 3'b000);
    case (instr_func)
      5'b00000, 5'b00001, 5'b00010, 5'b00011, 5'b00100,
      5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10100,
      5'b10110, 5'b10111, 5'b11000, 5'b11001, 5'b11010,
      5'b11011, 5'b11111: writes = alu_sel;
      default:            writes = 1'b0;
    endcase
  end

  // R10: no selected instruction, no change anywhere
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !alu_sel |=> $stable(acc_flat) &&
                 $stable({flag_zero, flag_neg, flag_carry, flag_ovf}));

  // R4: compare never writes an accumulator
  a_r4_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_sel && instr_func == 5'b00101) |=> $stable(acc_flat));

  // R7: clear leaves zero in the destination and raises the zero flag
  a_r7_clr_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_sel && instr_func == 5'b11001) |=>
      (acc_flat[$past(instr_dst)*ACC_W +: ACC_W] == '0) && flag_zero);

  // R8: magnitude result is never negative
  a_r8_abs_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_sel && instr_func == 5'b11011) |=>
      !acc_flat[$past(instr_dst)*ACC_W + ACC_W - 1] && !flag_carry);

  // R9: zero and negative flags agree with the value written back
  a_r9_flags_match_result: assert property (@(posedge clk) disable iff (!rst_n)
    writes |=>
      (flag_zero == (acc_flat[$past(instr_dst)*ACC_W +: ACC_W] == '0)) &&
      (flag_neg  ==  acc_flat[$past(instr_dst)*ACC_W + ACC_W - 1]));

endmodule

bind dsp_acc_alu dsp_acc_alu_chk #(
  .ACC_W   (ACC_W),
  .NUM_ACC (NUM_ACC),
  .AW      (AW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .instr_valid (instr_valid),
  .instr_op    (instr_op),
  .instr_func  (instr_func),
  .instr_dst   (instr_dst),
  .acc_flat    (acc_flat),
  .flag_zero   (flag_zero),
  .flag_neg    (flag_neg),
  .flag_carry  (flag_carry),
  .flag_ovf    (flag_ovf)
);

// File: tb/tb_dsp_acc_alu.sv
module tb_dsp_acc_alu;

  localparam int CLK_PERIOD = 10;
  localparam int NACC = 4;
  localparam int AW_T = 12;

  logic        clk;
  logic        rst_n;
  logic        instr_valid;
  logic [2:0]  instr_op;
  logic [4:0]  instr_func;
  logic [1:0]  instr_dst;
  logic [1:0]  instr_src;
  logic [5:0]  instr_imm;
  logic [47:0] acc_flat;
  logic        flag_zero, flag_neg, flag_carry, flag_ovf;

  dsp_acc_alu dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_op    (instr_op),
    .instr_func  (instr_func),
    .instr_dst   (instr_dst),
    .instr_src   (instr_src),
    .instr_imm   (instr_imm),
    .acc_flat    (acc_flat),
    .flag_zero   (flag_zero),
    .flag_neg    (flag_neg),
    .flag_carry  (flag_carry),
    .flag_ovf    (flag_ovf)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [11:0] m_acc [NACC];
  logic [3:0]  m_fl;            // {z, n, c, v}

  localparam logic [4:0] FUNCS [18] = '{
    5'b00000, 5'b00001, 5'b00010, 5'b00011, 5'b00100, 5'b00101,
    5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10100, 5'b10110,
    5'b10111, 5'b11000, 5'b11001, 5'b11010, 5'b11011, 5'b11111 };

  function automatic string req_tag(input logic v, input logic [2:0] op,
                                    input logic [4:0] f);
    if (!(v && op == 3'b000)) return "R10";
    case (f)
      5'b00000, 5'b00001:                     return "R2 R9 R11";
      5'b00010, 5'b00011, 5'b00100:           return "R3 R9 R11";
      5'b00101:                               return "R4 R9";
      5'b10000, 5'b10001, 5'b10010,
      5'b10011, 5'b10100:                     return "R5 R9 R11";
      5'b10111, 5'b11000, 5'b11010:           return "R6 R9 R11";
      5'b10110, 5'b11001, 5'b11111:           return "R7 R9 R11";
      5'b11011:                               return "R8 R9 R11";
      default:                                return "R10";
    endcase
  endfunction

  function automatic bit out_of_range(input int x);
    return (x > 2047) || (x < -2048);
  endfunction

  function automatic void model(input logic v, input logic [2:0] op,
                                input logic [4:0] f, input logic [1:0] d,
                                input logic [1:0] s, input logic [5:0] im);
    int sa, sb, ua, ub, r;
    bit c, ov, wr, known;
    logic [11:0] res;
    if (!(v && op == 3'b000)) return;
    sa = $signed(m_acc[d]);
    ua = int'(m_acc[d]);
    if (f[4]) sb = $signed(im);
    else      sb = $signed(m_acc[s]);
    ub = sb & 32'hFFF;
    c = 0; ov = 0; wr = 1; known = 1; r = 0;
    case (f)
      5'b00000, 5'b10000: begin r = ua + ub; c = r[12]; ov = out_of_range(sa + sb); end
      5'b00001, 5'b10001: begin r = ua - ub; c = ua < ub; ov = out_of_range(sa - sb); end
      5'b00101: begin r = ua - ub; c = ua < ub; ov = out_of_range(sa - sb); wr = 0; end
      5'b00010, 5'b10010: r = ua & ub;
      5'b00011, 5'b10011: r = ua | ub;
      5'b00100, 5'b10100: r = ua ^ ub;
      5'b10110: r = ~ua;
      5'b10111: begin r = ua + 1; c = r[12]; ov = (sa == 2047); end
      5'b11000: begin r = ua - 1; c = (ua == 0); ov = (sa == -2048); end
      5'b11001: r = 0;
      5'b11010: begin r = -sa; c = (ua != 0); ov = (sa == -2048); end
      5'b11011: begin
        if (sa == -2048) begin r = 2047; ov = 1; end
        else if (sa < 0) r = -sa;
        else             r = sa;
      end
      5'b11111: r = ua;
      default: known = 0;
    endcase
    if (!known) return;
    res  = r[11:0];
    m_fl = {res == 12'd0, res[11], c, ov};
    if (wr) m_acc[d] = res;
  endfunction

  task automatic compare(input string tag);
    logic [47:0] exp_flat;
    for (int i = 0; i < NACC; i++) exp_flat[i*AW_T +: AW_T] = m_acc[i];
    checks++;
    if (acc_flat !== exp_flat ||
        {flag_zero, flag_neg, flag_carry, flag_ovf} !== m_fl) begin
      errors++;
      $display("FAIL %s: acc=%h flags=%b expected acc=%h flags=%b",
               tag, acc_flat, {flag_zero, flag_neg, flag_carry, flag_ovf},
               exp_flat, m_fl);
    end
  endtask

  task automatic issue(input logic v, input logic [2:0] op, input logic [4:0] f,
                       input logic [1:0] d, input logic [1:0] s,
                       input logic [5:0] im);
    instr_valid = v; instr_op = op; instr_func = f;
    instr_dst = d; instr_src = s; instr_imm = im;
    model(v, op, f, d, s, im);
    @(posedge clk);
    @(negedge clk);
    compare(req_tag(v, op, f));
    instr_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    for (int i = 0; i < NACC; i++) m_acc[i] = '0;
    m_fl = '0;
    rst_n = 1'b0;
    instr_valid = 1'b0; instr_op = '0; instr_func = '0;
    instr_dst = '0; instr_src = '0; instr_imm = '0;
    repeat (3) @(negedge clk);
    compare("R1 reset state");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5: sign-extended immediates
    issue(1, 3'b000, 5'b10000, 2'd0, 2'd0, 6'b100000);   // acc0 = -32
    issue(1, 3'b000, 5'b10000, 2'd1, 2'd0, 6'b011111);   // acc1 = 31
    // R2: self-add doubling toward the most negative value, same-register read/write
    for (int k = 0; k < 6; k++) issue(1, 3'b000, 5'b00000, 2'd0, 2'd0, 6'd0);
    // R8: magnitude of -2048 saturates
    issue(1, 3'b000, 5'b11001, 2'd2, 2'd0, 6'd0);        // R7 clear acc2
    issue(1, 3'b000, 5'b00000, 2'd2, 2'd0, 6'd0);        // acc2 = -2048
    issue(1, 3'b000, 5'b11010, 2'd2, 2'd0, 6'd0);        // R6 negate min
    issue(1, 3'b000, 5'b11011, 2'd2, 2'd0, 6'd0);        // R8 abs -> 2047
    issue(1, 3'b000, 5'b10111, 2'd2, 2'd0, 6'd0);        // R6 inc overflow
    issue(1, 3'b000, 5'b11011, 2'd1, 2'd0, 6'd0);        // R8 positive unchanged
    issue(1, 3'b000, 5'b00101, 2'd1, 2'd2, 6'd0);        // R4 compare
    issue(1, 3'b000, 5'b11001, 2'd3, 2'd0, 6'd0);
    issue(1, 3'b000, 5'b11000, 2'd3, 2'd0, 6'd0);        // R6 dec 0 -> -1 borrow
    issue(1, 3'b000, 5'b10110, 2'd3, 2'd0, 6'd0);        // R7 not
    issue(1, 3'b000, 5'b00011, 2'd1, 2'd2, 6'd0);        // R3 or
    issue(1, 3'b000, 5'b11111, 2'd1, 2'd0, 6'd0);        // R7 pass
    // R10: ignored cases
    issue(0, 3'b000, 5'b11001, 2'd1, 2'd0, 6'd0);
    issue(1, 3'b011, 5'b11001, 2'd1, 2'd0, 6'd0);
    issue(1, 3'b000, 5'b10101, 2'd1, 2'd0, 6'd0);
    issue(1, 3'b000, 5'b01000, 2'd1, 2'd0, 6'd0);

    // constrained random mix
    for (int n = 0; n < 800; n++) begin
      logic v;
      logic [2:0] op;
      logic [4:0] f;
      v  = ($urandom % 10) != 0;
      op = (($urandom % 8) != 0) ? 3'b000 : 3'($urandom);
      f  = (($urandom % 12) != 0) ? FUNCS[$urandom % 18] : 5'($urandom);
      issue(v, op, f, 2'($urandom), 2'($urandom), 6'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule